// File: doc/BRIEF.md
# Constant Coefficient Signed-Digit Multiplier

This block multiplies a signed input sample by a coefficient that is fixed when the design is built. The coefficient is written as signed digits, each +1, -1 or 0. The block uses only shifts, additions and subtractions; no general multiplier is inferred. Two digit masks carry the coefficient: a plus mask and a minus mask. Bit i of each mask is the digit of weight 2^i. A mask pair that sets the same bit in both masks is an illegal digit, and elaboration rejects it.

When a group of digits holding two or more non-zero digits appears at least twice without overlap, the block builds that group's partial product once, at the group's lowest weight. It then adds copies of it shifted left, one per occurrence. The digits left outside the occurrences are summed as single terms. The sum is registered once, so the product appears one clock after its sample.

Top module: `csd_const_mult`

## Requirements
- R1: A synchronous active-high `rst` clears `product` to zero at the next rising clock edge, whatever the value of `x`.
- R2: `product` changes only at a rising clock edge. After the edge it holds the result for the `x` sampled at that edge, so the latency is one cycle.
- R3: The coefficient value is c = sum over i of (POS_DIGITS[i] - NEG_DIGITS[i]) * 2^i. With GUARD_W = 1, `product` equals x * c exactly for every input value, including the most negative one.
- R4: A minus digit subtracts its shifted input. A coefficient whose highest non-zero digit is a minus digit gives a correctly signed, exact product.
- R5: A coefficient with no non-zero digit drives `product` to zero for every input.
- R6: The shared group is the longest digit group with at least two non-zero digits that occurs at least twice without overlap. Occurrences are found scanning from the most significant end. Coefficients that share stay exact, because the group is computed at its lowest weight and shifted left for each occurrence.
- R7: Non-zero digits outside every occurrence of the shared group are added or subtracted as separate terms. The result stays exact when such digits sit between occurrences.
- R8: A group that occurs three times is computed once and reused for all three places, and the result is exact.
- R9: `product` is IN_W + MAX_POWER + GUARD_W bits wide. With GUARD_W = 0 it is the low IN_W + MAX_POWER bits of x * c in two's complement, wrapping when the exact value does not fit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| x | input | IN_W | Signed input sample |
| product | output | IN_W+MAX_POWER+GUARD_W | Registered signed product x * c |

## Verification
The bench builds seven copies of the block, each with an 8-bit input, and drives them with all 256 input values:
- 102, from a four-digit group repeated twice, with MAX_POWER 7.
- 1638, from a group repeated three times.
- 1820, from a six-digit group with long zero runs.
- 419, which shares a group and keeps a lone plus digit between its occurrences.
- -5, whose digits are all minus, so the top digit is negative.
- An all-zero coefficient.
- 5 with GUARD_W = 0, where the most negative inputs push the product past the narrow output and wrap.

Together these reach the sharing rule in its double, triple and gapped forms, the flat path, negative top digits, the zero case and the width limit.

// File: rtl/csd_pkg.sv
package csd_pkg;

  localparam int MAXD = 64;
  typedef logic [MAXD-1:0] dmask_t;

  // number of non-zero digits in powers lo .. lo+len-1
  function automatic int nnz_in(dmask_t p, dmask_t n, int lo, int len);
    int c = 0;
    for (int k = 0; k < len; k++) if (p[lo+k] || n[lo+k]) c++;
    return c;
  endfunction

  // group with top power t equals group with top power u
  function automatic bit same_group(dmask_t p, dmask_t n, int t, int u, int len);
    for (int k = 0; k < len; k++)
      if (p[t-k] != p[u-k] || n[t-k] != n[u-k]) return 1'b0;
    return 1'b1;
  endfunction

  // greedy non-overlapping occurrences, scanning from the top power down
  function automatic int count_occ(dmask_t p, dmask_t n, int nd, int t, int len);
    int c = 0;
    int u = nd - 1;
    while (u - len + 1 >= 0) begin
      if (same_group(p, n, t, u, len)) begin
        c++;
        u = u - len;
      end else begin
        u = u - 1;
      end
    end
    return c;
  endfunction

  // picks the shared group; returns its length (want_top=0) or top power (1)
  function automatic int share_pick(dmask_t p, dmask_t n, int nd, bit want_top);
    for (int len = nd / 2; len >= 2; len--)
      for (int t = nd - 1; t >= len - 1; t--)
        if (nnz_in(p, n, t - len + 1, len) >= 2 && count_occ(p, n, nd, t, len) >= 2)
          return want_top ? t : len;
    return 0;
  endfunction

  // marks either the lowest power of each occurrence (full=0) or all covered powers (1)
  function automatic dmask_t place_mask(dmask_t p, dmask_t n, int nd, int t, int len, bit full);
    dmask_t m = '0;
    int u = nd - 1;
    if (len < 2) return m;
    while (u - len + 1 >= 0) begin
      if (same_group(p, n, t, u, len)) begin
        if (full) begin
          for (int k = 0; k < len; k++) m[u-k] = 1'b1;
        end else begin
          m[u-len+1] = 1'b1;
        end
        u = u - len;
      end else begin
        u = u - 1;
      end
    end
    return m;
  endfunction

  // digits of the group rebased so that its lowest power becomes weight 1
  function automatic dmask_t group_mask(dmask_t m, int t, int len);
    dmask_t g = '0;
    for (int r = 0; r < len; r++) g[r] = m[t-len+1+r];
    return g;
  endfunction

  function automatic longint coef_value(dmask_t p, dmask_t n, int nd);
    longint v = 0;
    for (int i = 0; i < nd; i++) begin
      if (p[i]) v = v + (longint'(1) <<< i);
      if (n[i]) v = v - (longint'(1) <<< i);
    end
    return v;
  endfunction

endpackage

// File: rtl/csd_term_sum.sv
module csd_term_sum #(
  parameter int IN_W = 8,
  parameter int NDIG = 8,
  parameter int OUT_W = 17,
  parameter csd_pkg::dmask_t POS = '0,
  parameter csd_pkg::dmask_t NEG = '0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [IN_W-1:0]  x,
  output logic signed [OUT_W-1:0] sum
);
  localparam logic signed [OUT_W-1:0] VAL = OUT_W'(csd_pkg::coef_value(POS, NEG, NDIG));

  logic signed [OUT_W-1:0] x_ext;
  logic signed [OUT_W-1:0] term [NDIG];
  logic signed [OUT_W-1:0] acc;

  assign x_ext = OUT_W'(x);

  for (genvar i = 0; i < NDIG; i++) begin : g_term
    if (POS[i]) begin : g_add
      assign term[i] = x_ext <<< i;
    end else if (NEG[i]) begin : g_sub
      assign term[i] = -(x_ext <<< i);
    end else begin : g_none
      assign term[i] = '0;
    end
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < NDIG; i++) acc = acc + term[i];
  end

  assign sum = acc;

  // R7: shift-add sum must equal the true product of its digit subset
  assert_term_sum_R7: assert property (@(posedge clk) disable iff (rst)
    sum == x_ext * VAL);

endmodule

// File: rtl/csd_group_place.sv
module csd_group_place #(
  parameter int W = 17,
  parameter int NDIG = 8,
  parameter csd_pkg::dmask_t OCC = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic signed [W-1:0] grp,
  output logic signed [W-1:0] placed
);
  localparam logic signed [W-1:0] OCC_VAL = W'(csd_pkg::coef_value(OCC, '0, NDIG));

  logic signed [W-1:0] copy [NDIG];
  logic signed [W-1:0] acc;

  for (genvar i = 0; i < NDIG; i++) begin : g_copy
    if (OCC[i]) begin : g_on
      assign copy[i] = grp <<< i;
    end else begin : g_off
      assign copy[i] = '0;
    end
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < NDIG; i++) acc = acc + copy[i];
  end

  assign placed = acc;

  // R6: left-shifted copies together scale the group by the occurrence weights
  assert_group_place_R6: assert property (@(posedge clk) disable iff (rst)
    placed == grp * OCC_VAL);

endmodule

// File: rtl/csd_out_reg.sv
module csd_out_reg #(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic signed [W-1:0] d,
  output logic signed [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/csd_const_mult.sv
module csd_const_mult #(
  parameter int IN_W = 8,
  parameter int MAX_POWER = 7,
  parameter int GUARD_W = 1,
  parameter logic [MAX_POWER:0] POS_DIGITS = 8'h88,
  parameter logic [MAX_POWER:0] NEG_DIGITS = 8'h22
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic signed [IN_W-1:0]                x,
  output logic signed [IN_W+MAX_POWER+GUARD_W-1:0] product
);
  import csd_pkg::*;

  localparam int NDIG   = MAX_POWER + 1;
  localparam int FULL_W = IN_W + NDIG;
  localparam int OUT_W  = IN_W + MAX_POWER + GUARD_W;

  localparam dmask_t P_M = dmask_t'(POS_DIGITS);
  localparam dmask_t N_M = dmask_t'(NEG_DIGITS);

  localparam int SH_LEN = share_pick(P_M, N_M, NDIG, 1'b0);
  localparam int SH_TOP = share_pick(P_M, N_M, NDIG, 1'b1);

  localparam dmask_t OCC   = place_mask(P_M, N_M, NDIG, SH_TOP, SH_LEN, 1'b0);
  localparam dmask_t COVER = place_mask(P_M, N_M, NDIG, SH_TOP, SH_LEN, 1'b1);
  localparam dmask_t G_POS = group_mask(P_M, SH_TOP, SH_LEN);
  localparam dmask_t G_NEG = group_mask(N_M, SH_TOP, SH_LEN);
  localparam dmask_t GAP_POS = P_M & ~COVER;
  localparam dmask_t GAP_NEG = N_M & ~COVER;

  localparam logic signed [FULL_W-1:0] COEF_V = FULL_W'(coef_value(P_M, N_M, NDIG));

  if ((POS_DIGITS & NEG_DIGITS) != '0) begin : g_bad_digit
    $error("a digit position is marked both plus and minus");
  end
  if (GUARD_W < 0 || GUARD_W > 1 || FULL_W > 64 || NDIG > MAXD) begin : g_bad_size
    $error("unsupported width parameters");
  end

  logic signed [FULL_W-1:0] shared_sum;
  logic signed [FULL_W-1:0] gap_sum;
  logic signed [FULL_W-1:0] total;
  logic signed [FULL_W-1:0] x_ext;

  if (SH_LEN >= 2) begin : g_share
    logic signed [FULL_W-1:0] grp_val;

    csd_term_sum #(
      .IN_W(IN_W), .NDIG(NDIG), .OUT_W(FULL_W), .POS(G_POS), .NEG(G_NEG)
    ) i_group (
      .clk(clk), .rst(rst), .x(x), .sum(grp_val)
    );

    csd_group_place #(
      .W(FULL_W), .NDIG(NDIG), .OCC(OCC)
    ) i_place (
      .clk(clk), .rst(rst), .grp(grp_val), .placed(shared_sum)
    );
  end else begin : g_flat
    assign shared_sum = '0;
  end

  csd_term_sum #(
    .IN_W(IN_W), .NDIG(NDIG), .OUT_W(FULL_W), .POS(GAP_POS), .NEG(GAP_NEG)
  ) i_gaps (
    .clk(clk), .rst(rst), .x(x), .sum(gap_sum)
  );

  assign total = shared_sum + gap_sum;
  assign x_ext = FULL_W'(x);

  csd_out_reg #(.W(OUT_W)) i_out (
    .clk(clk), .rst(rst), .d(total[OUT_W-1:0]), .q(product)
  );

  // R1: the cycle after reset the product is zero
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> product == '0);

  // R3 / R9: registered product matches the integer product of the last sample
  assert_exact_product_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> product == OUT_W'($past(x_ext) * COEF_V));

  if (P_M == '0 && N_M == '0) begin : g_zero_chk
    // R5: all-zero coefficient keeps the output at zero
    assert_zero_coeff_R5: assert property (@(posedge clk) disable iff (rst)
      product == '0);
  end

endmodule

// File: tb/test_csd_const_mult.sv
`timescale 1ns/1ps
module test_csd_const_mult;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [7:0] x = '0;

  logic signed [15:0] p_dbl;
  logic signed [19:0] p_tri;
  logic signed [19:0] p_long;
  logic signed [17:0] p_gap;
  logic signed [10:0] p_neg;
  logic signed [10:0] p_zero;
  logic signed [9:0]  p_wrap;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  csd_const_mult #(.IN_W(8), .MAX_POWER(7), .GUARD_W(1),
    .POS_DIGITS(8'h88), .NEG_DIGITS(8'h22)) i_csd_const_mult (
    .clk(clk), .rst(rst), .x(x), .product(p_dbl));

  csd_const_mult #(.IN_W(8), .MAX_POWER(11), .GUARD_W(1),
    .POS_DIGITS(12'h888), .NEG_DIGITS(12'h222)) i_csd_const_mult_tri (
    .clk(clk), .rst(rst), .x(x), .product(p_tri));

  csd_const_mult #(.IN_W(8), .MAX_POWER(11), .GUARD_W(1),
    .POS_DIGITS(12'h820), .NEG_DIGITS(12'h104)) i_csd_const_mult_long (
    .clk(clk), .rst(rst), .x(x), .product(p_long));

  csd_const_mult #(.IN_W(8), .MAX_POWER(9), .GUARD_W(1),
    .POS_DIGITS(10'h224), .NEG_DIGITS(10'h081)) i_csd_const_mult_gap (
    .clk(clk), .rst(rst), .x(x), .product(p_gap));

  csd_const_mult #(.IN_W(8), .MAX_POWER(2), .GUARD_W(1),
    .POS_DIGITS(3'b000), .NEG_DIGITS(3'b101)) i_csd_const_mult_neg (
    .clk(clk), .rst(rst), .x(x), .product(p_neg));

  csd_const_mult #(.IN_W(8), .MAX_POWER(2), .GUARD_W(1),
    .POS_DIGITS(3'b000), .NEG_DIGITS(3'b000)) i_csd_const_mult_zero (
    .clk(clk), .rst(rst), .x(x), .product(p_zero));

  csd_const_mult #(.IN_W(8), .MAX_POWER(2), .GUARD_W(0),
    .POS_DIGITS(3'b101), .NEG_DIGITS(3'b000)) i_csd_const_mult_wrap (
    .clk(clk), .rst(rst), .x(x), .product(p_wrap));

  function automatic longint get_out(int sel);
    case (sel)
      0: return longint'(p_dbl);
      1: return longint'(p_tri);
      2: return longint'(p_long);
      3: return longint'(p_gap);
      4: return longint'(p_neg);
      5: return longint'(p_zero);
      default: return longint'(p_wrap);
    endcase
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drives every 8-bit input and compares with x*coef, kept to ow bits
  task automatic sweep(string tag, int sel, longint coef, int ow);
    for (int v = -128; v < 128; v++) begin
      longint e;
      @(negedge clk);
      x = 8'(v);
      @(negedge clk);
      e = longint'(v) * coef;
      e = (e <<< (64 - ow)) >>> (64 - ow);
      chk(tag, get_out(sel), e);
    end
  endtask

  task automatic t_reset;
    rst = 1'b1;
    x = 8'sd77;
    @(negedge clk);
    @(negedge clk);
    chk("R1 reset dbl", get_out(0), 0);
    chk("R1 reset tri", get_out(1), 0);
    chk("R1 reset wrap", get_out(6), 0);
    rst = 1'b0;
    x = 8'sd1;
    @(negedge clk);
    chk("R2 first sample", get_out(0), 102);
  endtask

  task automatic t_latency;
    @(negedge clk);
    x = 8'sd0;
    @(negedge clk);
    chk("R2 settle", get_out(0), 0);
    x = 8'sd3;
    #1;
    chk("R2 held before edge", get_out(0), 0);
    @(negedge clk);
    chk("R2 after edge", get_out(0), 306);
  endtask

  task automatic t_reset_mid;
    @(negedge clk);
    x = -8'sd100;
    @(negedge clk);
    chk("R1 pre-reset value", get_out(3), -41900);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid-run reset", get_out(3), 0);
    rst = 1'b0;
  endtask

  task automatic t_shared_double;  sweep("R3 R6 double group", 0, 102, 16);  endtask
  task automatic t_shared_triple;  sweep("R8 triple group", 1, 1638, 20);    endtask
  task automatic t_long_group;     sweep("R6 long group", 2, 1820, 20);       endtask
  task automatic t_gap_digit;      sweep("R7 gap digit", 3, 419, 18);         endtask
  task automatic t_leading_minus;  sweep("R4 leading minus", 4, -5, 11);      endtask
  task automatic t_zero_coef;      sweep("R5 zero coefficient", 5, 0, 11);    endtask
  task automatic t_wrap;           sweep("R9 narrow wrap", 6, 5, 10);         endtask

  task automatic t_corners;
    @(negedge clk);
    x = -8'sd128;
    @(negedge clk);
    chk("R3 most negative", get_out(0), -13056);
    chk("R4 most negative", get_out(4), 640);
    chk("R9 wrap value", get_out(6), 384);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_latency();
    t_shared_double();
    t_shared_triple();
    t_long_group();
    t_gap_digit();
    t_leading_minus();
    t_zero_coef();
    t_wrap();
    t_corners();
    t_reset_mid();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule